// File: doc/BRIEF.md
# DMA bus cycle sequencer

This block performs a single DMA transfer cycle on a processor bus once the channel arbiter has picked a channel and the host processor has granted the bus. When a start request arrives together with the hold acknowledge, the block captures the transfer's 16-bit memory address, the transfer kind, the write-timing option and the last-transfer flag. It then steps through a fixed five-cycle sequence.

The sequence opens with an address cycle. In that cycle the upper address byte is placed on the shared 8-bit data lines and a one-clock strobe lets an external latch capture it. The lower address byte has its own output. An address-enable output stays high for the whole cycle so that the processor's own buffers stay isolated. The block then raises the read strobe and the write strobe of the two sides involved, releases them, and pulses a done output to the register and arbiter blocks. A verify-kind transfer goes through the same address sequence but raises no strobe. All strobes are active high at this boundary, and the board inverts them where it needs to.

Cycles are counted from the clock edge that accepts a start. Cycle 1 is the clock period that follows that edge, and cycle 5 is the last.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is low, and after it is released with no start, every output is low.
- R2: A start is accepted on a rising edge where the block is idle and both `start_i` and `hold_ack_i` are high. In cycle 1 only, `addr_stb_o` and `data_oe_o` are high and `data_o` carries address bits 15:8. Otherwise `data_o` is zero. `addr_lo_o` carries address bits 7:0 in cycles 1 to 5 and is zero otherwise.
- R3: `addr_en_o` is high in cycles 1 to 5 and low at all other times.
- R4: Kind 2'b10 (memory to I/O) raises `mem_rd_o` in cycles 2 and 3. With normal timing it raises `io_wr_o` in cycle 3 only.
- R5: Kind 2'b01 (I/O to memory) raises `io_rd_o` in cycles 2 and 3. With normal timing it raises `mem_wr_o` in cycle 3 only.
- R6: When `ext_wr_i` is high at acceptance, the write strobe of R4 or R5 starts in cycle 2, together with the read strobe.
- R7: Kind 2'b00 (verify), and the unused code 2'b11, raise none of the four strobes. The address outputs, `addr_en_o` and `done_o` still follow R2, R3 and R8.
- R8: `done_o` is high in cycle 5 only. The block is idle in the cycle after that, and the earliest next acceptance is the edge that ends that idle cycle.
- R9: `tc_o` is high in cycles 1 to 5 when `last_i` was high at acceptance, and low otherwise.
- R10: Inputs are sampled only at acceptance. A start, or a change of address, kind or flags, during cycles 1 to 5 has no effect on the running cycle.
- R11: A start without `hold_ack_i` is not accepted, and all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arbiter request to run one cycle |
| hold_ack_i | input | 1 | Host bus grant |
| addr_i | input | 16 | Memory address for this transfer |
| kind_i | input | 2 | Transfer kind: 00 verify, 01 I/O to memory, 10 memory to I/O, 11 treated as verify |
| ext_wr_i | input | 1 | Early (extended) write strobe select |
| last_i | input | 1 | This is the final transfer of the channel |
| data_o | output | 8 | Upper address byte on the shared data lines |
| data_oe_o | output | 1 | Data line drive enable |
| addr_lo_o | output | 8 | Lower address byte |
| addr_stb_o | output | 1 | Latch strobe for the upper address byte |
| addr_en_o | output | 1 | Address enable, isolates the processor buffers |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| tc_o | output | 1 | Terminal count for the running cycle |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions check, on every cycle, the shape of the protocol. The latch strobe is a single clock inside the address-enable window, and nothing is driven outside that window. A write strobe only ever appears under a read strobe, opposite directions never overlap, done lasts one clock and is followed by release, and the terminal-count level holds steady for the whole cycle. The bench's reference model compares every output on every clock, and only its scenarios can show the rest. That covers which strobe pair each kind selects, where the normal and extended write strobes start, that verify raises nothing, that inputs are sampled at acceptance only, and that a start without the bus grant is ignored.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_RD   = 3'd2,
        S_RW   = 3'd3,
        S_REL  = 3'd4,
        S_DONE = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        K_VERIFY = 2'b00,
        K_IO2MEM = 2'b01,
        K_MEM2IO = 2'b10,
        K_RSVD   = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        seq_state_e state;
        xfer_kind_e kind;
        logic       ext;
        logic       last;
    } seq_ctx_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       hold_ack_i,
    input  logic [1:0] kind_i,
    input  logic       ext_wr_i,
    input  logic       last_i,
    output seq_ctx_t   ctx_o,
    output logic       accept_o
);

    seq_ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d    = ctx_q;
        accept_o = 1'b0;
        unique case (ctx_q.state)
            S_IDLE: begin
                if (start_i && hold_ack_i) begin
                    accept_o    = 1'b1;
                    ctx_d.state = S_ADDR;
                    ctx_d.kind  = xfer_kind_e'(kind_i);
                    ctx_d.ext   = ext_wr_i;
                    ctx_d.last  = last_i;
                end
            end
            S_ADDR:  ctx_d.state = S_RD;
            S_RD:    ctx_d.state = S_RW;
            S_RW:    ctx_d.state = S_REL;
            S_REL:   ctx_d.state = S_DONE;
            S_DONE:  ctx_d.state = S_IDLE;
            default: ctx_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{state: S_IDLE, kind: K_VERIFY, ext: 1'b0, last: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign ctx_o = ctx_q;

endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  seq_state_e        state_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic              addr_stb_o
);

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [DATA_W-1:0] hi_byte;
    logic              active;
    logic              hi_phase;

    always_comb begin
        addr_d = addr_q;
        if (accept_i) begin
            addr_d = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign hi_byte  = DATA_W'(addr_q >> DATA_W);
    assign active   = (state_i != S_IDLE);
    assign hi_phase = (state_i == S_ADDR);

    assign data_o     = hi_phase ? hi_byte : '0;
    assign data_oe_o  = hi_phase;
    assign addr_stb_o = hi_phase;
    assign addr_lo_o  = active ? addr_q[DATA_W-1:0] : '0;

endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
    import dma_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  xfer_kind_e kind_i,
    input  logic       ext_i,
    output logic       mem_rd_o,
    output logic       mem_wr_o,
    output logic       io_rd_o,
    output logic       io_wr_o
);

    logic rd_win;
    logic wr_win;
    logic to_io;
    logic to_mem;

    always_comb begin
        rd_win = (state_i == S_RD) || (state_i == S_RW);
        wr_win = (state_i == S_RW) || (ext_i && (state_i == S_RD));
        to_io  = (kind_i == K_MEM2IO);
        to_mem = (kind_i == K_IO2MEM);

        mem_rd_o = to_io  && rd_win;
        io_wr_o  = to_io  && wr_win;
        io_rd_o  = to_mem && rd_win;
        mem_wr_o = to_mem && wr_win;
    end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              hold_ack_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        kind_i,
    input  logic              ext_wr_i,
    input  logic              last_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic              addr_stb_o,
    output logic              addr_en_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              io_rd_o,
    output logic              io_wr_o,
    output logic              tc_o,
    output logic              done_o
);

    seq_ctx_t ctx;
    logic     accept;

    dma_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .hold_ack_i (hold_ack_i),
        .kind_i     (kind_i),
        .ext_wr_i   (ext_wr_i),
        .last_i     (last_i),
        .ctx_o      (ctx),
        .accept_o   (accept)
    );

    dma_seq_addr #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .addr_i     (addr_i),
        .state_i    (ctx.state),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .addr_lo_o  (addr_lo_o),
        .addr_stb_o (addr_stb_o)
    );

    dma_seq_strobe u_strobe (
        .state_i  (ctx.state),
        .kind_i   (ctx.kind),
        .ext_i    (ctx.ext),
        .mem_rd_o (mem_rd_o),
        .mem_wr_o (mem_wr_o),
        .io_rd_o  (io_rd_o),
        .io_wr_o  (io_wr_o)
    );

    assign addr_en_o = (ctx.state != S_IDLE);
    assign tc_o      = ctx.last && (ctx.state != S_IDLE);
    assign done_o    = (ctx.state == S_DONE);

endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic data_oe_o,
    input logic addr_stb_o,
    input logic addr_en_o,
    input logic mem_rd_o,
    input logic mem_wr_o,
    input logic io_rd_o,
    input logic io_wr_o,
    input logic tc_o,
    input logic done_o
);

    logic any_rd;
    logic any_wr;
    assign any_rd = mem_rd_o || io_rd_o;
    assign any_wr = mem_wr_o || io_wr_o;

    a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_o |=> !addr_stb_o);

    a_r2_stb_drive: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb_o |-> (data_oe_o && addr_en_o));

    a_r3_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en_o |-> !(any_rd || any_wr || tc_o || done_o || data_oe_o || addr_stb_o));

    a_r3_opens_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_en_o) |-> addr_stb_o);

    a_r4_rd_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_rd) |-> $past(addr_stb_o));

    a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && io_rd_o) && !(mem_wr_o && io_wr_o) && !(mem_rd_o && mem_wr_o));

    a_r6_wr_under_rd: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr |-> any_rd);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !addr_en_o));

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(any_rd || any_wr || addr_stb_o));

    a_r9_tc_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en_o && $past(addr_en_o)) |-> $stable(tc_o));

endmodule

bind dma_cycle_seq dma_cycle_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_oe_o  (data_oe_o),
    .addr_stb_o (addr_stb_o),
    .addr_en_o  (addr_en_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .io_rd_o    (io_rd_o),
    .io_wr_o    (io_wr_o),
    .tc_o       (tc_o),
    .done_o     (done_o)
);

// File: tb/tb_dma_cycle_seq.sv
module tb_dma_cycle_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        hold_ack_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [1:0]  kind_i = '0;
    logic        ext_wr_i = 1'b0;
    logic        last_i = 1'b0;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic [7:0]  addr_lo_o;
    logic        addr_stb_o;
    logic        addr_en_o;
    logic        mem_rd_o;
    logic        mem_wr_o;
    logic        io_rd_o;
    logic        io_wr_o;
    logic        tc_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    bit finished = 1'b0;

    // Reference model state: phase 0 idle, 1..5 the cycles of a transfer.
    int          m_phase = 0;
    logic [15:0] m_addr = '0;
    int          m_kind = 0;
    bit          m_ext = 1'b0;
    bit          m_last = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_cycle_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .hold_ack_i (hold_ack_i),
        .addr_i     (addr_i),
        .kind_i     (kind_i),
        .ext_wr_i   (ext_wr_i),
        .last_i     (last_i),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .addr_lo_o  (addr_lo_o),
        .addr_stb_o (addr_stb_o),
        .addr_en_o  (addr_en_o),
        .mem_rd_o   (mem_rd_o),
        .mem_wr_o   (mem_wr_o),
        .io_rd_o    (io_rd_o),
        .io_wr_o    (io_wr_o),
        .tc_o       (tc_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Behavioural reference model (R2, R8, R10, R11 acceptance rules).
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_phase <= 0;
        end else if (m_phase == 0) begin
            if (start_i && hold_ack_i) begin
                m_phase <= 1;
                m_addr  <= addr_i;
                m_kind  <= int'(kind_i);
                m_ext   <= ext_wr_i;
                m_last  <= last_i;
            end
        end else if (m_phase == 5) begin
            m_phase <= 0;
        end else begin
            m_phase <= m_phase + 1;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            int  p;
            bit  rdw, wrw, to_io, to_mem;
            int  e_data, e_lo, e_strobes, a_strobes;
            p       = m_phase;
            rdw     = (p == 2) || (p == 3);
            wrw     = (p == 3) || (m_ext && p == 2);
            to_io   = (m_kind == 2);
            to_mem  = (m_kind == 1);
            e_data  = (p == 1) ? int'(m_addr[15:8]) : 0;
            e_lo    = (p > 0) ? int'(m_addr[7:0]) : 0;
            e_strobes = {28'd0, to_io && rdw, to_mem && wrw, to_mem && rdw, to_io && wrw};
            a_strobes = {28'd0, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o};
            chk(addr_stb_o == (p == 1) && data_oe_o == (p == 1), "R2 strobe/oe",
                {addr_stb_o, data_oe_o}, {(p == 1), (p == 1)});
            chk(int'(data_o) == e_data, "R2 data_o", int'(data_o), e_data);
            chk(int'(addr_lo_o) == e_lo, "R2 addr_lo_o", int'(addr_lo_o), e_lo);
            chk(addr_en_o == (p > 0), "R3 addr_en_o", addr_en_o, (p > 0));
            chk(a_strobes == e_strobes, "R4/R5/R6/R7 strobes", a_strobes, e_strobes);
            chk(done_o == (p == 5), "R8 done_o", done_o, (p == 5));
            chk(tc_o == (m_last && p > 0), "R9 tc_o", tc_o, (m_last && p > 0));
        end
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transfer; inputs are scrambled during the cycle to exercise R10.
    task automatic run_xfer(input logic [15:0] a, input logic [1:0] k,
                            input bit ext, input bit last);
        @(negedge clk);
        start_i = 1'b1; hold_ack_i = 1'b1;
        addr_i = a; kind_i = k; ext_wr_i = ext; last_i = last;
        @(negedge clk);
        start_i = 1'b1;
        addr_i = ~a; kind_i = ~k; ext_wr_i = ~ext; last_i = ~last;
        idle(3);
        start_i = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        // R1: outputs low under reset
        chk({data_o, data_oe_o, addr_lo_o, addr_stb_o, addr_en_o, mem_rd_o,
             mem_wr_o, io_rd_o, io_wr_o, tc_o, done_o} == '0, "R1 reset outputs",
            {data_o, addr_lo_o}, 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        idle(3);
        chk(!addr_en_o && !done_o, "R1 idle after reset", addr_en_o, 0);

        // R4 read kind, normal timing, terminal count (R9)
        run_xfer(16'hA55A, 2'b10, 1'b0, 1'b1);
        // R5 write kind, normal timing
        run_xfer(16'h1234, 2'b01, 1'b0, 1'b0);
        // R6 extended write on both kinds
        run_xfer(16'hBEEF, 2'b10, 1'b1, 1'b0);
        run_xfer(16'h0F0F, 2'b01, 1'b1, 1'b1);
        // R7 verify and the unused code
        run_xfer(16'hC3C3, 2'b00, 1'b1, 1'b1);
        run_xfer(16'h8001, 2'b11, 1'b0, 1'b0);

        // R11: start with no hold acknowledge
        @(negedge clk);
        start_i = 1'b1; hold_ack_i = 1'b0; addr_i = 16'hFFFF; kind_i = 2'b10;
        idle(4);
        chk(!addr_en_o && !mem_rd_o, "R11 no grant no cycle", addr_en_o, 0);
        start_i = 1'b0;

        // R8/R10: start held high for back-to-back transfers
        @(negedge clk);
        start_i = 1'b1; hold_ack_i = 1'b1; addr_i = 16'h7E81; kind_i = 2'b01;
        ext_wr_i = 1'b0; last_i = 1'b0;
        idle(6);
        chk(!addr_en_o, "R8 idle gap after done", addr_en_o, 0);
        idle(1);
        chk(addr_en_o && addr_stb_o, "R8 next accepted after gap", addr_stb_o, 1);
        start_i = 1'b0;
        idle(8);

        // R2 address byte walk
        for (int i = 0; i < 8; i++) begin
            run_xfer(16'(16'h0101 << i), 2'(i % 4), 1'(i[0]), 1'(i[1]));
        end
        idle(4);
        compare_on = 1'b0;
        finish_run();
    end

endmodule